// File: doc/BRIEF.md
# Debug Port Host Command Shifter

This block is the host (debugger) end of a full-duplex, single-clock serial debug link. A command made of a mode bit, a control bit and a payload is offered on a valid/ready input. Once accepted, the block holds the link idle until the target shows it is ready by pulling its response line low. It then generates the debug clock from a programmable half-period divider. On the command line it sends a start bit, the mode bit, the control bit and the payload. Over the same bit times it captures the target's response frame from the response line.

The link is full duplex and pipelined: the reply that arrives during a frame belongs to the command that was sent before it. Frame length depends on the mode bit. A short frame carries 7 payload bits and a long frame carries 32. When the target never becomes ready, a programmable wait limit ends the attempt and returns a reply marked as timed out.

Top module: `dbgh_host_shifter`

## Requirements
- R1: During and right after reset, dbg_clk is 1, dbg_cmd is 0, cmd_ready is 1 and rsp_valid is 0.
- R2: After a command is accepted, no falling edge appears on dbg_clk and dbg_cmd stays 0 as long as dbg_rsp is high.
- R3: A frame sends, MSB first, a start bit of 1, then cmd_mode, then cmd_ctrl, then the payload. With cmd_mode=1 the frame is 10 bits long and the payload is cmd_data[6:0], so the upper bits are ignored. With cmd_mode=0 it is 35 bits long and the payload is cmd_data[31:0].
- R4: The response frame is sampled on the same bit times. Bit 0 is the ready bit (0), then status0, then status1, then the data field MSB first. The data field is 7 bits for short frames and 32 bits for long frames. A short response appears zero-extended on rsp_data.
- R5: Each frame has exactly as many dbg_clk falling edges as it has bits. Each low phase of dbg_clk lasts cfg_half_div clock cycles.
- R6: dbg_cmd changes only while dbg_clk is high. It is updated together with the rising edge, and the target samples it on the falling edge.
- R7: If dbg_rsp stays high, rsp_valid pulses with rsp_timeout=1 exactly cfg_wait_limit cycles after acceptance. In that case status0, status1 and rsp_data are 0 and dbg_clk never toggles.
- R8: cmd_ready is low from acceptance until the reply. rsp_valid is a one-cycle pulse, given exactly once per accepted command.
- R9: Between frames, dbg_clk rests high and dbg_cmd rests low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_half_div | input | DIV_W | Half period of dbg_clk in clk cycles |
| cfg_wait_limit | input | WAIT_W | Cycles allowed for the target to become ready |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted when high together with cmd_valid |
| cmd_mode | input | 1 | 1 selects a short frame, 0 a long frame |
| cmd_ctrl | input | 1 | Control bit sent after the mode bit |
| cmd_data | input | LONG_DATA | Payload (low SHORT_DATA bits used in short frames) |
| dbg_clk | output | 1 | Debug clock to the target |
| dbg_cmd | output | 1 | Serial command line to the target |
| dbg_rsp | input | 1 | Serial response line from the target |
| rsp_valid | output | 1 | One-cycle reply strobe |
| rsp_status0 | output | 1 | First status bit of the reply |
| rsp_status1 | output | 1 | Second status bit of the reply |
| rsp_data | output | LONG_DATA | Reply data, zero-extended for short frames |
| rsp_timeout | output | 1 | Reply ended by the ready-wait limit |

## Verification
The assertions assume that cfg_half_div is at least SYNC_STAGES+1 and stays constant during a frame. They also assume the target only changes dbg_rsp right after a rising dbg_clk, and sends a ready bit of 0 at the start of each frame. The bench models the target so that it moves its line only on dbg_clk rising edges. It changes the divider and the wait limit only while the block is idle, and uses half periods of 3 to 6 cycles. It raises and drops the busy level only between frames, and it lets that level pass through the synchronizer before it offers a command.

// File: rtl/dbgh_pkg.sv
// Shared types and default sizes for the debug host shifter.
// Assumes nothing beyond IEEE 1800-2017.
package dbgh_pkg;
    localparam int LONG_DATA_W  = 32;
    localparam int SHORT_DATA_W = 7;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_SHIFT
    } host_state_e;
endpackage

// File: rtl/dbgh_sync.sv
// Multi-flop synchronizer for the asynchronous target response line.
// Assumes STAGES >= 1; the reset value is the "target busy" level.
module dbgh_sync #(
    parameter int STAGES    = 2,
    parameter bit RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            // First stage samples the raw line.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[i] <= RESET_VAL;
                else        chain[i] <= d;
            end
        end else begin : g_next
            // Later stages pass the value along the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[i] <= RESET_VAL;
                else        chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/dbgh_half_timer.sv
// Half-period timer: while run is high, tick pulses once every half_div
// cycles (a half_div of 0 behaves as 1). Restarts from zero when run drops.
module dbgh_half_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half_div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] last;

    // Terminal count of one half period.
    always_comb last = (half_div == '0) ? '0 : half_div - DIV_W'(1);

    assign tick = run && (cnt == last);

    // Count cycles inside the current half period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (tick)      cnt <= '0;
        else                cnt <= cnt + DIV_W'(1);
    end
endmodule

// File: rtl/dbgh_frame_shift.sv
// Frame shifter: holds the outgoing frame MSB first and collects the
// incoming bits LSB-side. Assumes load, step and sample are never
// asserted in the same cycle.
module dbgh_frame_shift #(
    parameter int FRAME_W = 35
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [FRAME_W-1:0] load_frame,
    input  logic               step,
    input  logic               sample,
    input  logic               rx_bit,
    output logic               tx_bit,
    output logic [FRAME_W-1:0] rx_word
);
    logic [FRAME_W-1:0] tx_sr;

    // Outgoing bits: load left-aligned, move one place per bit time.
    always_ff @(posedge clk) begin
        if (!rst_n)    tx_sr <= '0;
        else if (load) tx_sr <= load_frame;
        else if (step) tx_sr <= {tx_sr[FRAME_W-2:0], 1'b0};
    end

    // Incoming bits: cleared per command so short replies read zero above.
    always_ff @(posedge clk) begin
        if (!rst_n || load) rx_word <= '0;
        else if (sample)    rx_word <= {rx_word[FRAME_W-2:0], rx_bit};
    end

    assign tx_bit = tx_sr[FRAME_W-1];
endmodule

// File: rtl/dbgh_host_shifter.sv
// Debug host command shifter. Accepts one command, waits for the target
// to pull dbg_rsp low, then clocks out a 10- or 35-bit frame while
// collecting the target's reply. Assumes cfg_half_div > SYNC_STAGES and
// that configuration is stable while a command is in flight.
module dbgh_host_shifter
    import dbgh_pkg::*;
#(
    parameter int DIV_W       = 8,
    parameter int WAIT_W      = 16,
    parameter int SYNC_STAGES = 2,
    parameter int LONG_DATA   = LONG_DATA_W,
    parameter int SHORT_DATA  = SHORT_DATA_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [DIV_W-1:0]     cfg_half_div,
    input  logic [WAIT_W-1:0]    cfg_wait_limit,
    input  logic                 cmd_valid,
    output logic                 cmd_ready,
    input  logic                 cmd_mode,
    input  logic                 cmd_ctrl,
    input  logic [LONG_DATA-1:0] cmd_data,
    output logic                 dbg_clk,
    output logic                 dbg_cmd,
    input  logic                 dbg_rsp,
    output logic                 rsp_valid,
    output logic                 rsp_status0,
    output logic                 rsp_status1,
    output logic [LONG_DATA-1:0] rsp_data,
    output logic                 rsp_timeout
);
    localparam int LONG_LEN  = LONG_DATA + 3;
    localparam int SHORT_LEN = SHORT_DATA + 3;
    localparam int CNT_W     = $clog2(LONG_LEN);
    localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_LEN - 1);
    localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_LEN - 1);

    host_state_e          state;
    logic                 clk_q, low_phase, short_q, rsp_sync, tick, tx_bit;
    logic [CNT_W-1:0]     bit_cnt, frame_last;
    logic [WAIT_W-1:0]    wait_cnt, wait_last;
    logic [LONG_LEN-1:0]  load_frame, rx_word;
    logic                 load, step, sample, frame_end, ready_bit;
    logic                 st0_now, st1_now;
    logic [LONG_DATA-1:0] data_now;

    dbgh_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(dbg_rsp), .q(rsp_sync)
    );

    dbgh_half_timer #(.DIV_W(DIV_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(state == ST_SHIFT),
        .half_div(cfg_half_div), .tick(tick)
    );

    dbgh_frame_shift #(.FRAME_W(LONG_LEN)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(load), .load_frame(load_frame),
        .step(step), .sample(sample), .rx_bit(rsp_sync),
        .tx_bit(tx_bit), .rx_word(rx_word)
    );

    // Build the outgoing frame, left-aligned so the start bit leaves first.
    always_comb begin
        load_frame = '0;
        if (cmd_mode)
            load_frame[LONG_LEN-1 -: SHORT_LEN] =
                {1'b1, cmd_mode, cmd_ctrl, cmd_data[SHORT_DATA-1:0]};
        else
            load_frame = {1'b1, cmd_mode, cmd_ctrl, cmd_data};
    end

    // Pick reply fields out of the captured bits by frame size.
    always_comb begin
        if (short_q) begin
            ready_bit = rx_word[SHORT_LEN-1];
            st0_now   = rx_word[SHORT_DATA+1];
            st1_now   = rx_word[SHORT_DATA];
            data_now  = LONG_DATA'(rx_word[SHORT_DATA-1:0]);
        end else begin
            ready_bit = rx_word[LONG_LEN-1];
            st0_now   = rx_word[LONG_DATA+1];
            st1_now   = rx_word[LONG_DATA];
            data_now  = rx_word[LONG_DATA-1:0];
        end
    end

    // Strobes shared by the FSM and the shifter.
    always_comb begin
        frame_last = short_q ? SHORT_LAST : LONG_LAST;
        wait_last  = (cfg_wait_limit == '0) ? '0 : cfg_wait_limit - WAIT_W'(1);
        load       = (state == ST_IDLE) && cmd_valid;
        sample     = (state == ST_SHIFT) && tick && !low_phase;
        frame_end  = (state == ST_SHIFT) && tick && low_phase && (bit_cnt == frame_last);
        step       = (state == ST_SHIFT) && tick && low_phase && (bit_cnt != frame_last);
    end

    // Control FSM: accept, wait for target ready, run the bit clock, reply.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            clk_q       <= 1'b1;
            low_phase   <= 1'b0;
            short_q     <= 1'b0;
            bit_cnt     <= '0;
            wait_cnt    <= '0;
            rsp_valid   <= 1'b0;
            rsp_status0 <= 1'b0;
            rsp_status1 <= 1'b0;
            rsp_data    <= '0;
            rsp_timeout <= 1'b0;
        end else begin
            rsp_valid <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (cmd_valid) begin
                        short_q  <= cmd_mode;
                        wait_cnt <= '0;
                        state    <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (!rsp_sync) begin
                        bit_cnt   <= '0;
                        low_phase <= 1'b0;
                        state     <= ST_SHIFT;
                    end else if (wait_cnt >= wait_last) begin
                        rsp_valid   <= 1'b1;
                        rsp_timeout <= 1'b1;
                        rsp_status0 <= 1'b0;
                        rsp_status1 <= 1'b0;
                        rsp_data    <= '0;
                        state       <= ST_IDLE;
                    end else begin
                        wait_cnt <= wait_cnt + WAIT_W'(1);
                    end
                end
                ST_SHIFT: begin
                    if (tick && !low_phase) begin
                        clk_q     <= 1'b0;
                        low_phase <= 1'b1;
                    end else if (tick) begin
                        clk_q     <= 1'b1;
                        low_phase <= 1'b0;
                        if (frame_end) begin
                            rsp_valid   <= 1'b1;
                            rsp_timeout <= 1'b0;
                            rsp_status0 <= st0_now;
                            rsp_status1 <= st1_now;
                            rsp_data    <= data_now;
                            state       <= ST_IDLE;
                        end else begin
                            bit_cnt <= bit_cnt + CNT_W'(1);
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign cmd_ready = (state == ST_IDLE);
    assign dbg_clk   = clk_q;
    assign dbg_cmd   = (state == ST_SHIFT) && tx_bit;

    // R9: link rests with clock high and command low outside a frame.
    p_idle_levels_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_SHIFT) |-> (dbg_clk && !dbg_cmd));
    // R2: a busy target keeps the host from starting a frame.
    p_gate_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && rsp_sync) |=> (state != ST_SHIFT));
    // R6: the command line moves only while the debug clock is high.
    p_cmd_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dbg_cmd) |-> dbg_clk);
    // R8: the reply strobe lasts one cycle.
    p_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    // R8: an accepted command closes the input until the reply.
    p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_ready);
    // R7: a timed-out reply carries no status or data.
    p_timeout_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_timeout) |-> (rsp_data == '0 && !rsp_status0 && !rsp_status1));
    // R3: the bit counter stays inside the frame chosen at acceptance.
    p_bitcnt_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT) |-> (bit_cnt <= frame_last));
    // R4: the first bit captured in a completed frame is the ready bit 0.
    p_ready_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |-> !ready_bit);
endmodule

// File: tb/dbgh_host_shifter_test.sv
// Bench for the debug host shifter with a behavioural target model.
module dbgh_host_shifter_test;
    localparam int CLK_PERIOD = 10;
    localparam int NV         = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cfg_half_div = 8'd4;
    logic [15:0] cfg_wait_limit = 16'd1000;
    logic        cmd_valid = 1'b0, cmd_mode = 1'b0, cmd_ctrl = 1'b0;
    logic [31:0] cmd_data = '0;
    logic        cmd_ready, dbg_clk, dbg_cmd, dbg_rsp;
    logic        rsp_valid, rsp_status0, rsp_status1, rsp_timeout;
    logic [31:0] rsp_data;

    int n_checks = 0, n_err = 0;

    // Target model state.
    logic        tgt_busy = 1'b0;
    logic        tgt_line = 1'b0;
    logic [34:0] tgt_resp = '0;
    logic [34:0] tgt_rx = '0;
    int          tgt_len = 35;
    int          neg_cnt = 0, neg_base = 0, rsp_cnt = 0;
    longint      fall_t = 0, rise_t = 0;

    // Vector: mode, ctrl, cmd data, status0, status1, reply data, busy cycles, half div.
    localparam logic [83:0] VECS [NV] = '{
        {1'b0, 1'b0, 32'h7C769BA6, 1'b1, 1'b1, 32'hFFFFFFFF, 8'd0,  8'd4},
        {1'b0, 1'b1, 32'h01706F80, 1'b0, 1'b0, 32'h00141480, 8'd5,  8'd4},
        {1'b1, 1'b1, 32'h0000003F, 1'b1, 1'b0, 32'h00000055, 8'd0,  8'd5},
        {1'b1, 1'b0, 32'hFFFFFF80, 1'b0, 1'b1, 32'h0000007F, 8'd12, 8'd3},
        {1'b0, 1'b0, 32'h60000000, 1'b0, 1'b0, 32'h800DB530, 8'd3,  8'd6},
        {1'b1, 1'b1, 32'h00000000, 1'b1, 1'b1, 32'h00000000, 8'd0,  8'd4}
    };

    dbgh_host_shifter uut (
        .clk(clk), .rst_n(rst_n), .cfg_half_div(cfg_half_div),
        .cfg_wait_limit(cfg_wait_limit), .cmd_valid(cmd_valid),
        .cmd_ready(cmd_ready), .cmd_mode(cmd_mode), .cmd_ctrl(cmd_ctrl),
        .cmd_data(cmd_data), .dbg_clk(dbg_clk), .dbg_cmd(dbg_cmd),
        .dbg_rsp(dbg_rsp), .rsp_valid(rsp_valid), .rsp_status0(rsp_status0),
        .rsp_status1(rsp_status1), .rsp_data(rsp_data), .rsp_timeout(rsp_timeout)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    assign dbg_rsp = tgt_busy | tgt_line;

    // Target samples the command line on each falling debug clock.
    always @(negedge dbg_clk) begin
        tgt_rx  <= {tgt_rx[33:0], dbg_cmd};
        neg_cnt <= neg_cnt + 1;
        fall_t  <= $time;
    end

    // Target presents its next reply bit after each rising debug clock.
    always @(posedge dbg_clk) begin
        rise_t <= $time;
        if ((neg_cnt - neg_base) >= 1 && (neg_cnt - neg_base) < tgt_len)
            tgt_line <= tgt_resp[34 - (neg_cnt - neg_base)];
        else
            tgt_line <= 1'b0;
    end

    // Count reply strobes.
    always @(posedge clk) if (rsp_valid) rsp_cnt <= rsp_cnt + 1;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    endtask

    // Offer one command and return after the accepting edge and the next negedge.
    task automatic send(input logic mode, input logic ctrl, input logic [31:0] data);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_mode = mode; cmd_ctrl = ctrl; cmd_data = data;
        while (!cmd_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic run_vec(input logic [83:0] v);
        logic        mode, ctrl, s0, s1;
        logic [31:0] cdata, rdata, exp_data;
        logic [34:0] exp_frame, mask;
        int          busy, div, lat, cnt0;
        mode = v[83]; ctrl = v[82]; cdata = v[81:50]; s0 = v[49]; s1 = v[48];
        rdata = v[47:16]; busy = int'(v[15:8]); div = int'(v[7:0]);
        cfg_half_div = 8'(div);
        cfg_wait_limit = 16'd1000;
        tgt_len = mode ? 10 : 35;
        tgt_resp = mode ? {1'b0, s0, s1, rdata[6:0], 25'b0} : {1'b0, s0, s1, rdata};
        exp_frame = mode ? {25'b0, 1'b1, 1'b1, ctrl, cdata[6:0]} : {1'b1, 1'b0, ctrl, cdata};
        exp_data  = mode ? {25'b0, rdata[6:0]} : rdata;
        mask = (35'b1 << tgt_len) - 35'b1;
        neg_base = neg_cnt;
        cnt0 = rsp_cnt;
        if (busy > 0) begin
            tgt_busy = 1'b1;
            repeat (4) @(negedge clk);
        end
        send(mode, ctrl, cdata);
        check("R8 ready low after accept", 64'(cmd_ready), 64'd0);
        if (busy > 0) begin
            repeat (busy) @(negedge clk);
            check("R2 no clock while busy", 64'(neg_cnt - neg_base), 64'd0);
            check("R2 command low while busy", 64'(dbg_cmd), 64'd0);
            tgt_busy = 1'b0;
        end
        lat = 0;
        while (!rsp_valid && lat < 2000) begin
            @(negedge clk);
            lat++;
        end
        check("R4 status0", 64'(rsp_status0), 64'(s0));
        check("R4 status1", 64'(rsp_status1), 64'(s1));
        check("R4 data", 64'(rsp_data), 64'(exp_data));
        check("R7 no timeout on good frame", 64'(rsp_timeout), 64'd0);
        check("R3 frame bits", 64'(tgt_rx & mask), 64'(exp_frame));
        check("R5 falling edges", 64'(neg_cnt - neg_base), 64'(tgt_len));
        check("R5 low phase length", 64'(rise_t - fall_t), 64'(div * CLK_PERIOD));
        repeat (2) @(negedge clk);
        check("R9 idle clock high", 64'(dbg_clk), 64'd1);
        check("R9 idle command low", 64'(dbg_cmd), 64'd0);
        check("R8 single reply", 64'(rsp_cnt - cnt0), 64'd1);
        check("R8 ready again", 64'(cmd_ready), 64'd1);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        int lat, cnt0;
        // R1: reset state.
        repeat (5) @(posedge clk);
        @(negedge clk);
        check("R1 reset clock", 64'(dbg_clk), 64'd1);
        check("R1 reset command", 64'(dbg_cmd), 64'd0);
        check("R1 reset ready", 64'(cmd_ready), 64'd1);
        check("R1 reset valid", 64'(rsp_valid), 64'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 after reset clock", 64'(dbg_clk), 64'd1);
        check("R1 after reset valid", 64'(rsp_valid), 64'd0);

        // Table of vectors.
        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R7: target never ready.
        cfg_half_div = 8'd4;
        cfg_wait_limit = 16'd20;
        tgt_busy = 1'b1;
        repeat (4) @(negedge clk);
        neg_base = neg_cnt;
        cnt0 = rsp_cnt;
        send(1'b0, 1'b1, 32'hDEADBEEF);
        lat = 0;
        while (!rsp_valid && lat < 500) begin
            @(negedge clk);
            lat++;
        end
        check("R7 timeout latency", 64'(lat), 64'd20);
        check("R7 timeout flag", 64'(rsp_timeout), 64'd1);
        check("R7 timeout data", 64'(rsp_data), 64'd0);
        check("R7 timeout status", 64'({rsp_status0, rsp_status1}), 64'd0);
        check("R7 no clock on timeout", 64'(neg_cnt - neg_base), 64'd0);
        repeat (2) @(negedge clk);
        check("R8 one timeout reply", 64'(rsp_cnt - cnt0), 64'd1);
        check("R9 idle after timeout", 64'({dbg_clk, dbg_cmd}), 64'd2);
        tgt_busy = 1'b0;
        repeat (4) @(negedge clk);

        // Recovery after a timeout with a long and a short command.
        run_vec({1'b0, 1'b1, 32'hA5A5F00F, 1'b1, 1'b0, 32'h24000400, 8'd2, 8'd4});
        run_vec({1'b1, 1'b0, 32'h12345601, 1'b0, 1'b0, 32'h00000001, 8'd0, 8'd3});

        summary();
        $finish;
    end
endmodule